// File: doc/BRIEF.md
# Calendar Clock with Snapshot Register Access

This block keeps wall-clock time in BCD calendar form. A divider counts a 32.768 kHz timebase enable down to one advance per second, and each advance carries through seconds, minutes, hours, date, day of week, month, year and century. Month lengths and leap years are handled, and the hour field runs in either 24-hour or 12-hour AM/PM form.

Software reaches the clock through a byte-wide register port driven by an outer transaction engine. That engine reports three kinds of event. One marks the acknowledge before read data. One marks the acknowledge before write data. The last ends the transaction, either with a stop or with an abort. A read event freezes a full copy of the time, and every register read is served from that copy. A write event copies the running time into a shadow buffer, and incoming bytes overwrite only the fields they address. The shadow replaces the running time only when the transaction ends with a stop, and an abort discards it. The running time keeps advancing throughout. A one-cycle pulse marks each second.

Top module: `rtc_snap_top`

## Requirements
- R1: Every DIV timebase enables (DIV parameter, default 32768), the running time advances by one second, and `pps` is high for exactly one clock cycle. That cycle is the first in which the new time is visible.
- R2: Seconds and minutes count BCD 00..59. In 24-hour mode (hour bit 7 = 0), hours count BCD 00..23 in bits 5:0. Each field wraps to its lower bound and carries into the next field.
- R3: Hour bit 7 = 1 selects 12-hour mode. In this mode bits 4:0 hold BCD 01..12 and bit 5 is the PM flag. 11 goes to 12 and toggles PM. 12 goes to 01 with PM kept. 11 PM to 12 AM starts a new day.
- R4: The date counts from 01 to the month's last day: 28 or 29 for month 02, 30 for months 04, 06, 09 and 11, and 31 otherwise. A year is leap when it is divisible by 4. For year 00 the century must be divisible by 4.
- R5: Day of week counts 0..6 and advances with each new day. Month 12 wraps to 01 and increments the year. Year 99 wraps to 00 and increments the century, which is BCD 00..99.
- R6: Field addresses are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day of week, 7 century. `rd_snap` copies all fields into a read latch, and `reg_rdata` always shows the latched field at `reg_addr`. The latch does not change until the next `rd_snap`.
- R7: `wr_open` copies the running time into the shadow buffer. Each `reg_wr` pulse after it replaces only the addressed shadow field. A committed single-byte write therefore leaves every other field at its value as of `wr_open`.
- R8: `xfer_stop` after `wr_open` and at least one byte commits the shadow into the running time. `xfer_abort` discards the shadow. `reg_wr` without an open write, and a stop with no bytes written, leave the time unchanged.
- R9: A commit clears the divider phase, so the first advance after it comes exactly DIV timebase enables later.
- R10: After reset the time is 20 00-01-01 00:00:00, day 0, in 24-hour mode, and `pps` is low. The clock does not advance until the first commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz timebase rate |
| rd_snap | input | 1 | Acknowledge before read data: freeze the time into the read latch |
| wr_open | input | 1 | Acknowledge before write data: load the shadow from the running time |
| xfer_stop | input | 1 | Valid end of transaction: commit a pending write |
| xfer_abort | input | 1 | Invalid end of transaction: discard a pending write |
| reg_wr | input | 1 | Write strobe for one shadow field |
| reg_addr | input | 3 | Field address for reads and writes |
| reg_wdata | input | 8 | BCD write data |
| reg_rdata | output | 8 | Latched field at `reg_addr` |
| pps | output | 1 | One-cycle pulse per advanced second |

## Verification
A carry fault in the calendar is not visible at once. It appears only when a snapshot taken after the affected rollover is read. For that reason the bench reads all eight fields after runs that cross second, hour, day, month, year and century boundaries. A fault in the divider phase shows up as early or missing `pps` pulses within the first second after a commit. A fault in the shadow or the latch appears as stale or mixed fields on the very next read. Because reads go through the snapshot, every check of the running time first takes a snapshot and then reads from it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RTC_FIELDS = 8;
  localparam int A_SEC  = 0;
  localparam int A_MIN  = 1;
  localparam int A_HR   = 2;
  localparam int A_DATE = 3;
  localparam int A_MON  = 4;
  localparam int A_YR   = 5;
  localparam int A_DOW  = 6;
  localparam int A_CEN  = 7;

  typedef logic [RTC_FIELDS-1:0][7:0] rtc_time_t;

  // century 20, dow 0, year 00, month 01, date 01, 00:00:00
  localparam rtc_time_t RTC_RST = {8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  // BCD increment with wrap from hi back to lo
  function automatic logic [7:0] bcd_inc(input logic [7:0] v, input logic [7:0] lo,
                                         input logic [7:0] hi);
    if (v >= hi)          return lo;
    if (v[3:0] >= 4'd9)   return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // (10*t + u) mod 4 == (2*t + u) mod 4
  function automatic logic div4(input logic [7:0] v);
    logic [4:0] s;
    s = {v[7:4], 1'b0} + {1'b0, v[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic is_leap(input logic [7:0] yr, input logic [7:0] cen);
    if (yr == 8'h00) return div4(cen);
    return div4(yr);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick_en,
  input  logic          phase_clr,
  output logic          sec_tick,
  output logic          pps,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_d;

  assign sec_tick = run && tick_en && !phase_clr && (cnt == LAST);

  always_comb begin
    cnt_d = cnt;
    if (phase_clr || !run) begin
      cnt_d = '0;
    end else if (tick_en) begin
      cnt_d = (cnt == LAST) ? '0 : cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      pps <= 1'b0;
    end else begin
      cnt <= cnt_d;
      pps <= sec_tick;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t cur
);
  rtc_time_t nxt;
  logic      c_sec, c_min, c_day, c_date, c_mon, c_yr;
  logic [7:0] h;
  logic [7:0] last_day;

  always_comb begin
    nxt      = cur;
    h        = cur[A_HR];
    last_day = month_last(cur[A_MON], is_leap(cur[A_YR], cur[A_CEN]));
    c_sec    = (cur[A_SEC] >= 8'h59);
    c_min    = c_sec && (cur[A_MIN] >= 8'h59);
    c_day    = 1'b0;

    nxt[A_SEC] = bcd_inc(cur[A_SEC], 8'h00, 8'h59);
    if (c_sec) nxt[A_MIN] = bcd_inc(cur[A_MIN], 8'h00, 8'h59);

    if (c_min) begin
      if (h[7]) begin
        // 12-hour form: bit5 PM, bits4:0 BCD 01..12
        if (h[4:0] >= 5'h12) begin
          nxt[A_HR] = {h[7:5], 5'h01};
        end else if (h[4:0] == 5'h11) begin
          nxt[A_HR] = {h[7:6], ~h[5], 5'h12};
          c_day     = h[5];
        end else if (h[3:0] >= 4'd9) begin
          nxt[A_HR] = {h[7:5], 1'b1, 4'h0};
        end else begin
          nxt[A_HR] = {h[7:4], h[3:0] + 4'd1};
        end
      end else begin
        if (h[5:0] >= 6'h23) begin
          nxt[A_HR] = {h[7:6], 6'h00};
          c_day     = 1'b1;
        end else if (h[3:0] >= 4'd9) begin
          nxt[A_HR] = {h[7:6], h[5:4] + 2'd1, 4'h0};
        end else begin
          nxt[A_HR] = {h[7:4], h[3:0] + 4'd1};
        end
      end
    end

    c_date = c_day && (cur[A_DATE] >= last_day);
    c_mon  = c_date && (cur[A_MON] >= 8'h12);
    c_yr   = c_mon && (cur[A_YR] >= 8'h99);

    if (c_day) begin
      nxt[A_DATE] = bcd_inc(cur[A_DATE], 8'h01, last_day);
      nxt[A_DOW]  = bcd_inc(cur[A_DOW], 8'h00, 8'h06);
    end
    if (c_date) nxt[A_MON] = bcd_inc(cur[A_MON], 8'h01, 8'h12);
    if (c_mon)  nxt[A_YR]  = bcd_inc(cur[A_YR], 8'h00, 8'h99);
    if (c_yr)   nxt[A_CEN] = bcd_inc(cur[A_CEN], 8'h00, 8'h99);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= RTC_RST;
    end else if (load) begin
      cur <= load_val;
    end else if (adv) begin
      cur <= nxt;
    end
  end
endmodule

// File: rtl/rtc_access.sv
module rtc_access
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rtc_time_t  live,
  input  logic       rd_snap,
  input  logic       wr_open,
  input  logic       xfer_stop,
  input  logic       xfer_abort,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output rtc_time_t  rd_latch,
  output rtc_time_t  shadow,
  output logic       commit,
  output logic       running
);
  logic      armed, dirty;
  logic      armed_d, dirty_d, running_d;
  logic      end_xfer, wr_ok;
  rtc_time_t shadow_d, rd_latch_d;

  assign end_xfer  = xfer_stop || xfer_abort;
  assign wr_ok     = reg_wr && armed;
  assign commit    = xfer_stop && armed && dirty;
  assign reg_rdata = rd_latch[reg_addr];

  always_comb begin
    armed_d    = armed;
    dirty_d    = dirty;
    shadow_d   = shadow;
    rd_latch_d = rd_latch;
    running_d  = running || commit;
    if (end_xfer) begin
      armed_d = 1'b0;
      dirty_d = 1'b0;
    end else if (wr_open) begin
      armed_d  = 1'b1;
      dirty_d  = 1'b0;
      shadow_d = live;
    end else if (wr_ok) begin
      dirty_d            = 1'b1;
      shadow_d[reg_addr] = reg_wdata;
    end
    if (rd_snap) rd_latch_d = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      dirty    <= 1'b0;
      running  <= 1'b0;
      shadow   <= RTC_RST;
      rd_latch <= RTC_RST;
    end else begin
      armed    <= armed_d;
      dirty    <= dirty_d;
      running  <= running_d;
      shadow   <= shadow_d;
      rd_latch <= rd_latch_d;
    end
  end
endmodule

// File: rtl/rtc_snap_top.sv
module rtc_snap_top
  import rtc_pkg::*;
#(
  parameter int unsigned DIV = 32768,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       rd_snap,
  input  logic       wr_open,
  input  logic       xfer_stop,
  input  logic       xfer_abort,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       pps
);
  logic          rst_meta, rst_sync_n;
  logic          sec_tick, commit, running;
  logic [CW-1:0] pre_cnt;
  rtc_time_t     live_t, rd_latch, shadow;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  rtc_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .run(running), .tick_en(tick_en),
    .phase_clr(commit), .sec_tick(sec_tick), .pps(pps), .cnt(pre_cnt)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_sync_n), .adv(sec_tick), .load(commit),
    .load_val(shadow), .cur(live_t)
  );

  rtc_access u_acc (
    .clk(clk), .rst_n(rst_sync_n), .live(live_t), .rd_snap(rd_snap),
    .wr_open(wr_open), .xfer_stop(xfer_stop), .xfer_abort(xfer_abort),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rd_latch(rd_latch), .shadow(shadow),
    .commit(commit), .running(running)
  );
endmodule

// File: rtl/rtc_snap_chk.sv
module rtc_snap_chk
  import rtc_pkg::*;
#(
  parameter int CW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pps,
  input logic          sec_tick,
  input logic          commit,
  input logic          running,
  input logic          rd_snap,
  input logic [CW-1:0] cnt,
  input rtc_time_t     live,
  input rtc_time_t     rd_latch
);
  // R1
  pps_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pps |=> !pps);

  // R1
  pps_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pps |-> running);

  // R2
  sec_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (live[A_SEC][3:0] <= 4'd9) && (live[A_SEC] <= 8'h59));

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_snap |=> $stable(rd_latch));

  // R8
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !commit) |=> $stable(live));

  // R9
  phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (cnt == '0) && !pps);

  // R10
  cold_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !commit) |=> $stable(live) && !pps);
endmodule

bind rtc_snap_top rtc_snap_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pps(pps), .sec_tick(sec_tick),
  .commit(commit), .running(running), .rd_snap(rd_snap), .cnt(pre_cnt),
  .live(live_t), .rd_latch(rd_latch)
);

// File: tb/rtc_snap_top_tb.sv
module rtc_snap_top_tb;
  localparam int DIV = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, tick_en, rd_snap, wr_open, xfer_stop, xfer_abort, reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       pps;

  rtc_snap_top #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rd_snap(rd_snap),
    .wr_open(wr_open), .xfer_stop(xfer_stop), .xfer_abort(xfer_abort),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pps(pps)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  int m_sec, m_min, m_hr, m_date, m_dow, m_mon, m_yr, m_cen, m_12;

  function automatic logic [7:0] tobcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_in(input int mo, input int yr, input int ce);
    int full;
    bit leap;
    full = ce * 100 + yr;
    leap = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
    if (mo == 2) return leap ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] enc(input int a);
    int h12;
    case (a)
      0: return tobcd(m_sec);
      1: return tobcd(m_min);
      2: begin
        if (m_12 != 0) begin
          h12 = (m_hr % 12 == 0) ? 12 : m_hr % 12;
          return 8'h80 | ((m_hr >= 12) ? 8'h20 : 8'h00) | tobcd(h12);
        end
        return tobcd(m_hr);
      end
      3: return tobcd(m_date);
      4: return tobcd(m_mon);
      5: return tobcd(m_yr);
      6: return tobcd(m_dow);
      default: return tobcd(m_cen);
    endcase
  endfunction

  task automatic model_inc();
    m_sec++;
    if (m_sec == 60) begin m_sec = 0; m_min++; end
    if (m_min == 60) begin m_min = 0; m_hr++; end
    if (m_hr == 24) begin
      m_hr = 0; m_dow = (m_dow + 1) % 7; m_date++;
      if (m_date > days_in(m_mon, m_yr, m_cen)) begin m_date = 1; m_mon++; end
      if (m_mon == 13) begin m_mon = 1; m_yr++; end
      if (m_yr == 100) begin m_yr = 0; m_cen = (m_cen + 1) % 100; end
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic snap();
    @(negedge clk) rd_snap = 1'b1;
    @(negedge clk) rd_snap = 1'b0;
  endtask

  task automatic open_wr();
    @(negedge clk) wr_open = 1'b1;
    @(negedge clk) wr_open = 1'b0;
  endtask

  task automatic stop_x();
    @(negedge clk) xfer_stop = 1'b1;
    @(negedge clk) xfer_stop = 1'b0;
  endtask

  task automatic abort_x();
    @(negedge clk) xfer_abort = 1'b1;
    @(negedge clk) xfer_abort = 1'b0;
  endtask

  task automatic wbyte(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk) reg_wr = 1'b0;
  endtask

  task automatic rbyte(input int a, output logic [7:0] d);
    reg_addr = 3'(a);
    #1 d = reg_rdata;
  endtask

  task automatic tick_one(output bit p);
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
    p = pps;
  endtask

  // advance n seconds; R1 pulse count is checked
  task automatic run_secs(input int n, input string tag);
    int pc;
    bit p;
    pc = 0;
    for (int i = 0; i < n * DIV; i++) begin
      tick_one(p);
      if (p) pc++;
    end
    for (int i = 0; i < n; i++) model_inc();
    chk({tag, " R1 pps count"}, 8'(pc), 8'(n));
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v;
    snap();
    for (int a = 0; a < 8; a++) begin
      rbyte(a, v);
      chk($sformatf("%s field%0d", tag, a), v, enc(a));
    end
  endtask

  task automatic set_model(input int ce, input int yr, input int mo, input int dt,
                           input int dw, input int hr, input int mn, input int sc,
                           input int h12);
    m_cen = ce; m_yr = yr; m_mon = mo; m_date = dt; m_dow = dw;
    m_hr = hr; m_min = mn; m_sec = sc; m_12 = h12;
  endtask

  task automatic write_model();
    open_wr();
    for (int a = 0; a < 8; a++) wbyte(a, enc(a));
    stop_x();
  endtask

  task automatic corner(input string tag, input int ce, input int yr, input int mo,
                        input int dt, input int dw, input int hr, input int mn,
                        input int sc, input int h12, input int n);
    set_model(ce, yr, mo, dt, dw, hr, mn, sc, h12);
    write_model();
    run_secs(n, tag);
    check_all(tag);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, old;
    bit p;
    int seed;
    seed = $urandom(1357);
    rst_n = 1'b0; tick_en = 1'b0; rd_snap = 1'b0; wr_open = 1'b0;
    xfer_stop = 1'b0; xfer_abort = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state and frozen clock
    chk("R10 pps after reset", 8'(pps), 8'h00);
    set_model(20, 0, 1, 1, 0, 0, 0, 0, 0);
    check_all("R10 reset");
    for (int i = 0; i < 3 * DIV; i++) begin
      tick_one(p);
      chk("R10 no pps before first write", 8'(p), 8'h00);
    end
    check_all("R10 cold hold");

    // R7 single-byte write keeps the other fields
    open_wr();
    wbyte(0, 8'h30);
    stop_x();
    m_sec = 30;
    check_all("R7 single byte");

    // R9 first advance exactly DIV enables after the stop
    for (int i = 0; i < DIV - 1; i++) begin
      tick_one(p);
      chk("R9 no early pps", 8'(p), 8'h00);
    end
    check_all("R9 before first second");
    tick_one(p);
    chk("R9 pps on DIV-th enable", 8'(p), 8'h01);
    model_inc();
    check_all("R9 after first second");

    // calendar corners
    corner("R5 century", 19, 99, 12, 31, 6, 23, 59, 58, 0, 3);
    corner("R4 leap 2024", 20, 24, 2, 28, 3, 23, 59, 59, 0, 1);
    corner("R4 common 2023", 20, 23, 2, 28, 2, 23, 59, 59, 0, 1);
    corner("R4 leap 2000", 20, 0, 2, 28, 1, 23, 59, 59, 0, 1);
    corner("R4 no leap 2100", 21, 0, 2, 28, 0, 23, 59, 59, 0, 1);
    corner("R4 april end", 20, 25, 4, 30, 3, 23, 59, 59, 0, 2);
    corner("R2 hour carry", 20, 25, 6, 15, 0, 9, 59, 57, 0, 5);
    corner("R3 11am to 12pm", 20, 25, 7, 4, 5, 11, 59, 59, 1, 1);
    corner("R3 12pm to 1pm", 20, 25, 7, 4, 5, 12, 59, 59, 1, 1);
    corner("R3 11pm to 12am", 20, 25, 7, 4, 5, 23, 59, 59, 1, 1);
    corner("R3 12am to 1am", 20, 25, 7, 4, 5, 0, 59, 59, 1, 1);

    // R6 latch frozen while live time runs
    snap();
    rbyte(0, old);
    run_secs(2, "R6 run");
    rbyte(0, v);
    chk("R6 latch frozen", v, old);
    check_all("R6 fresh snapshot");

    // R8 abort discards
    open_wr();
    wbyte(0, 8'h05);
    wbyte(1, 8'h07);
    abort_x();
    check_all("R8 abort");
    // R8 write strobe without an open write
    wbyte(2, 8'h05);
    stop_x();
    check_all("R8 unopened write");
    // R8 stop with no bytes
    open_wr();
    stop_x();
    run_secs(1, "R8 empty");
    check_all("R8 empty stop");

    // R7 shadow taken at open, live runs meanwhile
    begin
      int s_sec, s_min, s_hr, s_date, s_dow, s_mon, s_yr, s_cen;
      open_wr();
      s_sec = m_sec; s_min = m_min; s_hr = m_hr; s_date = m_date;
      s_dow = m_dow; s_mon = m_mon; s_yr = m_yr; s_cen = m_cen;
      run_secs(2, "R7 run");
      wbyte(1, 8'h42);
      stop_x();
      set_model(s_cen, s_yr, s_mon, s_date, s_dow, s_hr, 42, s_sec, m_12);
      check_all("R7 shadow at open");
    end

    // random times near rollovers
    for (int k = 0; k < 20; k++) begin
      int ce, yr, mo, dt;
      ce = 19 + int'($urandom % 3);
      yr = int'($urandom % 100);
      mo = 1 + int'($urandom % 12);
      dt = 1 + int'($urandom % days_in(mo, yr, ce));
      if ($urandom % 2 == 0) dt = days_in(mo, yr, ce);
      set_model(ce, yr, mo, dt, int'($urandom % 7), int'($urandom % 24),
                55 + int'($urandom % 5), 50 + int'($urandom % 10),
                int'($urandom % 2));
      if ($urandom % 2 == 0) m_hr = 23;
      write_model();
      run_secs(1 + int'($urandom % 70), "R2 random");
      check_all("R2 R4 R5 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule